// File: doc/BRIEF.md
# Accumulator ALU with Flag Register

This block is the arithmetic core of a small 8-bit processor built around an accumulator. Every cycle it takes the accumulator byte and one operand byte and produces the next accumulator value together with a write enable. Alongside that it keeps a four-bit flag register (zero, subtract, half-carry, carry) that is updated on the clock edge of every accepted operation. The two-operand group is add, add with carry, subtract, subtract with borrow, AND, XOR, OR and compare. The single-operand group is complement, set carry, flip carry and decimal adjust.

The result path is purely combinational: `acc_out` and `acc_we` follow the inputs within the same cycle, and the processor writes the accumulator on the edge that also loads the flags. The carry, subtract and half-carry values that feed an operation come from the flag register. The processor does not supply them. When no operation is selected, the accumulator passes through unchanged, the write enable stays low and the flags hold.

Top module: `acc_alu_core`

## Requirements
- R1: After a synchronous active-low reset the flag byte `flags_out` reads 0x00. Its layout is zero at bit 7, subtract at bit 6, half-carry at bit 5 and carry at bit 4. Bits 3:0 are always zero.
- R2: With `alu_en` high, `op_sel` 000 (add) gives acc+opnd and 001 (add with carry) gives acc+opnd+C, both modulo 256. Subtract is cleared. Half-carry is set when the low-nibble sum, including any carry-in, exceeds 0xF. Carry is set when the 9-bit sum exceeds 0xFF. Zero follows the result.
- R3: `op_sel` 010 (subtract) gives acc-opnd and 011 (subtract with borrow) gives acc-opnd-C. Subtract is set. Half-carry is set when the operand low nibble plus the borrow-in exceeds the accumulator low nibble. Carry is set when the operand plus the borrow-in, taken as a 9-bit value, exceeds the accumulator. Zero follows the result.
- R4: `op_sel` 100 (AND) sets half-carry. 101 (XOR) and 110 (OR) clear half-carry. All three clear subtract and carry and set zero from the result.
- R5: `op_sel` 111 (compare) produces the flags that subtract would produce. It holds `acc_we` low and passes `acc_in` through to `acc_out`.
- R6: Every two-operand operation other than compare raises `acc_we` in the same cycle.
- R7: With `unary_en` high and `unary_sel` 00 (complement), `acc_out` is the bitwise inverse of `acc_in` and `acc_we` is high. Subtract and half-carry are set, and zero and carry are kept.
- R8: `unary_sel` 01 (set carry) sets carry and 10 (flip carry) inverts it. Both clear subtract and half-carry, keep zero, and hold `acc_we` low.
- R9: `unary_sel` 11 (decimal adjust) works in two steps. If half-carry is set or the low nibble exceeds 9, it adds 0x06, or subtracts 0x06 when the subtract flag is set. Then, if the high nibble of that value exceeds 9, it adds 0x60, or subtracts it when subtract is set, and sets carry; otherwise carry is cleared. Zero follows the result, half-carry is cleared and subtract is kept.
- R10: With neither `alu_en` nor `unary_en` high, `acc_we` is low, `acc_out` equals `acc_in` and the flags hold.
- R11: When `alu_en` and `unary_en` are both high, the two-operand operation is performed and the single-operand command is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alu_en | input | 1 | Perform the two-operand operation this cycle |
| op_sel | input | 3 | Two-operand operation select |
| unary_en | input | 1 | Perform the single-operand command this cycle |
| unary_sel | input | 2 | Single-operand command select |
| acc_in | input | 8 | Current accumulator value |
| opnd_in | input | 8 | Second operand |
| acc_out | output | 8 | Next accumulator value (combinational) |
| acc_we | output | 1 | Accumulator write enable (combinational) |
| flags_out | output | 8 | Registered flag byte |

## Verification
The checker takes for granted that the enables and selects are known (0 or 1) at every rising edge after reset. Its next-cycle flag properties also assume reset is not asserted in the cycle that follows the operation. The bench drives every input from time zero, changes inputs only on falling edges, and releases reset once before any operation. Flag preconditions for carry-in and for decimal adjust are set up through the block's own operations rather than by forcing state. The sweeps therefore stay inside the operating conditions the checker relies on.

// File: rtl/acc_alu_pkg.sv
// Shared types for the accumulator ALU: operation codes, the stored
// flag nibble and the bit position of each flag in the output byte.
// Assumes an 8-bit flag byte whose low nibble is always zero.
package acc_alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'b000,
        OP_ADC = 3'b001,
        OP_SUB = 3'b010,
        OP_SBC = 3'b011,
        OP_AND = 3'b100,
        OP_XOR = 3'b101,
        OP_OR  = 3'b110,
        OP_CMP = 3'b111
    } alu_op_e;

    typedef enum logic [1:0] {
        UN_CPL = 2'b00,
        UN_SCF = 2'b01,
        UN_CCF = 2'b10,
        UN_DAA = 2'b11
    } un_op_e;

    // Field order matches the flag byte from bit 7 down to bit 4.
    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flag_nib_t;

    localparam int FLAG_Z_BIT = 7;
    localparam int FLAG_N_BIT = 6;
    localparam int FLAG_H_BIT = 5;
    localparam int FLAG_C_BIT = 4;
    localparam int FLAG_BYTE_W = 8;

endpackage

// File: rtl/acc_alu_arith.sv
// Two-operand datapath: add, add with carry, subtract, subtract with
// borrow, AND, XOR, OR and compare. Purely combinational.
// Assumes DATA_W is even; half-carry is taken at the low half-word.
module acc_alu_arith
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              cin_i,
    input  alu_op_e           op_i,
    output logic [DATA_W-1:0] res_o,
    output flag_nib_t         fl_o,
    output logic              we_o
);

    localparam int NIB_W = DATA_W / 2;

    logic              use_cin;
    logic [DATA_W:0]   sum_w;
    logic [NIB_W:0]    hsum_w;
    logic [DATA_W:0]   bsub_w;
    logic [NIB_W:0]    hbsub_w;
    logic [DATA_W-1:0] diff_w;
    logic              borrow;
    logic              hborrow;

    // Carry/borrow-in applies only to the "with carry" variants.
    always_comb begin
        use_cin = cin_i && (op_i == OP_ADC || op_i == OP_SBC);
    end

    // Adder and subtractor share the same effective carry-in.
    always_comb begin
        sum_w   = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, use_cin};
        hsum_w  = {1'b0, a_i[NIB_W-1:0]} + {1'b0, b_i[NIB_W-1:0]}
                + {{NIB_W{1'b0}}, use_cin};
        bsub_w  = {1'b0, b_i} + {{DATA_W{1'b0}}, use_cin};
        hbsub_w = {1'b0, b_i[NIB_W-1:0]} + {{NIB_W{1'b0}}, use_cin};
        diff_w  = a_i - b_i - {{(DATA_W-1){1'b0}}, use_cin};
        borrow  = bsub_w > {1'b0, a_i};
        hborrow = hbsub_w > {1'b0, a_i[NIB_W-1:0]};
    end

    // Result, flags and write enable per operation.
    always_comb begin
        res_o = a_i;
        fl_o  = '0;
        we_o  = 1'b1;
        unique case (op_i)
            OP_ADD, OP_ADC: begin
                res_o = sum_w[DATA_W-1:0];
                fl_o.h = hsum_w[NIB_W];
                fl_o.c = sum_w[DATA_W];
                fl_o.z = (sum_w[DATA_W-1:0] == '0);
            end
            OP_SUB, OP_SBC: begin
                res_o  = diff_w;
                fl_o.n = 1'b1;
                fl_o.h = hborrow;
                fl_o.c = borrow;
                fl_o.z = (diff_w == '0);
            end
            OP_CMP: begin
                res_o  = a_i;
                we_o   = 1'b0;
                fl_o.n = 1'b1;
                fl_o.h = hborrow;
                fl_o.c = borrow;
                fl_o.z = (diff_w == '0);
            end
            OP_AND: begin
                res_o  = a_i & b_i;
                fl_o.h = 1'b1;
                fl_o.z = ((a_i & b_i) == '0);
            end
            OP_XOR: begin
                res_o  = a_i ^ b_i;
                fl_o.z = ((a_i ^ b_i) == '0);
            end
            OP_OR: begin
                res_o  = a_i | b_i;
                fl_o.z = ((a_i | b_i) == '0);
            end
            default: begin
                res_o = a_i;
                we_o  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/acc_alu_unary.sv
// Single-operand commands: complement, set carry, flip carry and
// decimal adjust. Purely combinational; reads the current flags.
// Assumes DATA_W is even; decimal correction steps scale per nibble.
module acc_alu_unary
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  flag_nib_t         fl_i,
    input  un_op_e            sel_i,
    output logic [DATA_W-1:0] res_o,
    output flag_nib_t         fl_o,
    output logic              we_o
);

    localparam int                NIB_W  = DATA_W / 2;
    localparam logic [DATA_W-1:0] LO_FIX = DATA_W'(6);
    localparam logic [DATA_W-1:0] HI_FIX = DATA_W'(6) << NIB_W;
    localparam logic [NIB_W-1:0]  DEC_MAX = NIB_W'(9);

    logic [DATA_W-1:0] lo_step;
    logic [DATA_W-1:0] hi_step;
    logic              lo_fix;
    logic              hi_fix;

    // Decimal adjust: low-nibble correction, then high-nibble correction.
    always_comb begin
        lo_fix  = fl_i.h || (a_i[NIB_W-1:0] > DEC_MAX);
        lo_step = a_i;
        if (lo_fix) lo_step = fl_i.n ? (a_i - LO_FIX) : (a_i + LO_FIX);
        hi_fix  = lo_step[DATA_W-1:NIB_W] > DEC_MAX;
        hi_step = lo_step;
        if (hi_fix) hi_step = fl_i.n ? (lo_step - HI_FIX) : (lo_step + HI_FIX);
    end

    // Result, flags and write enable per command.
    always_comb begin
        res_o = a_i;
        fl_o  = fl_i;
        we_o  = 1'b0;
        unique case (sel_i)
            UN_CPL: begin
                res_o  = ~a_i;
                we_o   = 1'b1;
                fl_o.n = 1'b1;
                fl_o.h = 1'b1;
            end
            UN_SCF: begin
                fl_o.n = 1'b0;
                fl_o.h = 1'b0;
                fl_o.c = 1'b1;
            end
            UN_CCF: begin
                fl_o.n = 1'b0;
                fl_o.h = 1'b0;
                fl_o.c = ~fl_i.c;
            end
            UN_DAA: begin
                res_o  = hi_step;
                we_o   = 1'b1;
                fl_o.h = 1'b0;
                fl_o.c = hi_fix;
                fl_o.z = (hi_step == '0);
            end
            default: begin
                res_o = a_i;
            end
        endcase
    end

endmodule

// File: rtl/acc_alu_flagreg.sv
// Flag nibble storage with synchronous active-low reset and load enable.
// Assumes the loaded value is already the complete next flag state.
module acc_alu_flagreg
    import acc_alu_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load_i,
    input  flag_nib_t d_i,
    output flag_nib_t q_o
);

    // Hold flags unless an operation is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)      q_o <= '0;
        else if (load_i) q_o <= d_i;
    end

endmodule

// File: rtl/acc_alu_core.sv
// Accumulator ALU top: selects between the two-operand path and the
// single-operand path (two-operand wins), drives the combinational
// accumulator result and registers the flags on each accepted operation.
// Assumes the processor writes acc_out into its accumulator when acc_we is high.
module acc_alu_core
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alu_en,
    input  logic [2:0]        op_sel,
    input  logic              unary_en,
    input  logic [1:0]        unary_sel,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] opnd_in,
    output logic [DATA_W-1:0] acc_out,
    output logic              acc_we,
    output logic [7:0]        flags_out
);

    flag_nib_t         fl_q;
    flag_nib_t         fl_ar;
    flag_nib_t         fl_un;
    flag_nib_t         fl_nxt;
    logic [DATA_W-1:0] res_ar;
    logic [DATA_W-1:0] res_un;
    logic              we_ar;
    logic              we_un;

    acc_alu_arith #(.DATA_W(DATA_W)) u_arith (
        .a_i   (acc_in),
        .b_i   (opnd_in),
        .cin_i (fl_q.c),
        .op_i  (alu_op_e'(op_sel)),
        .res_o (res_ar),
        .fl_o  (fl_ar),
        .we_o  (we_ar)
    );

    acc_alu_unary #(.DATA_W(DATA_W)) u_unary (
        .a_i   (acc_in),
        .fl_i  (fl_q),
        .sel_i (un_op_e'(unary_sel)),
        .res_o (res_un),
        .fl_o  (fl_un),
        .we_o  (we_un)
    );

    // Priority select: two-operand path, then single-operand, then pass-through.
    always_comb begin
        if (alu_en) begin
            acc_out = res_ar;
            acc_we  = we_ar;
            fl_nxt  = fl_ar;
        end else if (unary_en) begin
            acc_out = res_un;
            acc_we  = we_un;
            fl_nxt  = fl_un;
        end else begin
            acc_out = acc_in;
            acc_we  = 1'b0;
            fl_nxt  = fl_q;
        end
    end

    acc_alu_flagreg u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (alu_en || unary_en),
        .d_i    (fl_nxt),
        .q_o    (fl_q)
    );

    // Assemble the flag byte; the low nibble is tied to zero.
    always_comb begin
        flags_out = '0;
        flags_out[FLAG_Z_BIT] = fl_q.z;
        flags_out[FLAG_N_BIT] = fl_q.n;
        flags_out[FLAG_H_BIT] = fl_q.h;
        flags_out[FLAG_C_BIT] = fl_q.c;
    end

endmodule

// File: rtl/acc_alu_chk.sv
// Assertion checker for acc_alu_core, attached by bind below.
// Assumes enables and selects are known at every edge after reset.
module acc_alu_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              alu_en,
    input logic [2:0]        op_sel,
    input logic              unary_en,
    input logic [1:0]        unary_sel,
    input logic [DATA_W-1:0] acc_in,
    input logic [DATA_W-1:0] acc_out,
    input logic              acc_we,
    input logic [7:0]        flags_out
);

    // R1
    low_nibble_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flags_out[3:0] == 4'h0);

    // R5
    cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_en && op_sel == 3'b111) |-> (!acc_we && acc_out == acc_in));

    // R3
    sub_sets_n_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_en && (op_sel == 3'b010 || op_sel == 3'b011 || op_sel == 3'b111))
        |=> flags_out[6]);

    // R4
    and_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_en && op_sel == 3'b100) |=> (flags_out[5] && !flags_out[6] && !flags_out[4]));

    // R7
    cpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!alu_en && unary_en && unary_sel == 2'b00) |-> (acc_we && acc_out == ~acc_in));

    // R8
    scf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!alu_en && unary_en && unary_sel == 2'b01)
        |=> (flags_out[4] && !flags_out[5] && !flags_out[6]));

    // R8
    ccf_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!alu_en && unary_en && unary_sel == 2'b10)
        |=> (flags_out[4] != $past(flags_out[4])));

    // R9
    daa_h_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!alu_en && unary_en && unary_sel == 2'b11) |=> !flags_out[5]);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!alu_en && !unary_en) |=> $stable(flags_out));

    // R10
    idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!alu_en && !unary_en) |-> (!acc_we && acc_out == acc_in));

endmodule

bind acc_alu_core acc_alu_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .alu_en    (alu_en),
    .op_sel    (op_sel),
    .unary_en  (unary_en),
    .unary_sel (unary_sel),
    .acc_in    (acc_in),
    .acc_out   (acc_out),
    .acc_we    (acc_we),
    .flags_out (flags_out)
);

// File: tb/acc_alu_core_tb_top.sv
// Self-checking bench: sweeps every two-operand operation over all
// accumulator values, a spread of operands and both carry-in values,
// plus decimal adjust under every subtract/half-carry combination.
module acc_alu_core_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       alu_en = 1'b0;
    logic [2:0] op_sel = 3'b000;
    logic       unary_en = 1'b0;
    logic [1:0] unary_sel = 2'b00;
    logic [7:0] acc_in = 8'h00;
    logic [7:0] opnd_in = 8'h00;
    logic [7:0] acc_out;
    logic       acc_we;
    logic [7:0] flags_out;

    int n_tests = 0;
    int n_fail = 0;
    logic [7:0] exp_flags = 8'h00;

    always #2.5 clk = ~clk;

    acc_alu_core dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .alu_en    (alu_en),
        .op_sel    (op_sel),
        .unary_en  (unary_en),
        .unary_sel (unary_sel),
        .acc_in    (acc_in),
        .opnd_in   (opnd_in),
        .acc_out   (acc_out),
        .acc_we    (acc_we),
        .flags_out (flags_out)
    );

    // Reference model: returns {we, acc, flags}.
    function automatic logic [16:0] model(input bit is_alu, input logic [2:0] op,
                                          input bit is_un, input logic [1:0] us,
                                          input logic [7:0] a, input logic [7:0] b,
                                          input logic [7:0] f);
        int ai = int'(a);
        int bi = int'(b);
        int ci = int'(f[4]);
        int r = ai;
        int cin;
        bit z = f[7], n = f[6], h = f[5], c = f[4], we = 0;
        if (is_alu) begin
            case (op)
                3'd0, 3'd1: begin
                    cin = (op == 3'd1) ? ci : 0;
                    r = ai + bi + cin;
                    h = ((ai % 16) + (bi % 16) + cin) > 15;
                    c = r > 255;
                    r = r % 256;
                    n = 0; we = 1;
                end
                3'd2, 3'd3, 3'd7: begin
                    cin = (op == 3'd3) ? ci : 0;
                    r = (ai - bi - cin + 512) % 256;
                    h = ((bi % 16) + cin) > (ai % 16);
                    c = (bi + cin) > ai;
                    n = 1; we = (op != 3'd7);
                end
                3'd4: begin r = ai & bi; h = 1; n = 0; c = 0; we = 1; end
                3'd5: begin r = ai ^ bi; h = 0; n = 0; c = 0; we = 1; end
                default: begin r = ai | bi; h = 0; n = 0; c = 0; we = 1; end
            endcase
            z = (r == 0);
            if (op == 3'd7) r = ai;
        end else if (is_un) begin
            case (us)
                2'd0: begin r = 255 - ai; n = 1; h = 1; we = 1; end
                2'd1: begin c = 1; n = 0; h = 0; end
                2'd2: begin c = !f[4]; n = 0; h = 0; end
                default: begin
                    if (f[5] || (ai % 16) > 9) r = f[6] ? r - 6 : r + 6;
                    r = (r + 256) % 256;
                    c = 0;
                    if ((r / 16) > 9) begin
                        r = f[6] ? r - 96 : r + 96;
                        c = 1;
                    end
                    r = (r + 256) % 256;
                    z = (r == 0); h = 0; we = 1;
                end
            endcase
        end
        return {we, r[7:0], z, n, h, c, 4'h0};
    endfunction

    function automatic string req_of(input bit is_alu, input logic [2:0] op,
                                     input bit is_un, input logic [1:0] us);
        if (is_alu) begin
            case (op)
                3'd0, 3'd1: return "R2/R6";
                3'd2, 3'd3: return "R3/R6";
                3'd7:       return "R5";
                default:    return "R4/R6";
            endcase
        end
        if (is_un) begin
            case (us)
                2'd0:    return "R7";
                2'd3:    return "R9";
                default: return "R8";
            endcase
        end
        return "R10";
    endfunction

    // Apply one operation for one cycle and check result and flags.
    task automatic run_op(input bit is_alu, input logic [2:0] op, input bit is_un,
                          input logic [1:0] us, input logic [7:0] a, input logic [7:0] b,
                          input string tag);
        logic [16:0] e;
        @(negedge clk);
        alu_en = is_alu; op_sel = op; unary_en = is_un; unary_sel = us;
        acc_in = a; opnd_in = b;
        e = model(is_alu, op, is_un, us, a, b, exp_flags);
        #1;
        n_tests++;
        if (acc_we !== e[16] || acc_out !== e[15:8]) begin
            n_fail++;
            $display("FAIL %s op=%0d/%0d a=%02h b=%02h: we/acc got %0b/%02h expected %0b/%02h",
                     tag, op, us, a, b, acc_we, acc_out, e[16], e[15:8]);
        end
        @(posedge clk);
        #1;
        n_tests++;
        if (flags_out !== e[7:0]) begin
            n_fail++;
            $display("FAIL %s op=%0d/%0d a=%02h b=%02h: flags got %02h expected %02h",
                     tag, op, us, a, b, flags_out, e[7:0]);
        end
        exp_flags = e[7:0];
    endtask

    function automatic logic [7:0] opnd_pick(input int k);
        case (k)
            0: return 8'h00;  1: return 8'h01;  2: return 8'h0F;  3: return 8'h10;
            4: return 8'h7F;  5: return 8'h80;  6: return 8'hF0;  7: return 8'hFF;
            8: return 8'h09;  9: return 8'h99; 10: return 8'h5A; default: return 8'hA5;
        endcase
    endfunction

    initial begin
        repeat (195000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        n_tests++;
        if (flags_out !== 8'h00) begin
            n_fail++;
            $display("FAIL R1 reset flags: got %02h expected 00", flags_out);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R10: idle cycle holds flags, passes accumulator through.
        run_op(1'b0, 3'd0, 1'b0, 2'd0, 8'h3C, 8'h11, "R10");
        run_op(0, 3'd0, 1, 2'd1, 8'h00, 8'h00, "R8");
        run_op(1'b0, 3'd0, 1'b0, 2'd0, 8'hC3, 8'h11, "R10");

        // R11: both enables high, two-operand path wins (AND clears carry).
        run_op(1'b1, 3'd4, 1'b1, 2'd1, 8'hF0, 8'h0F, "R11");
        run_op(1'b1, 3'd0, 1'b1, 2'd0, 8'h40, 8'h02, "R11");

        // R3: borrow with operand FF and borrow-in set.
        run_op(0, 3'd0, 1, 2'd1, 8'h00, 8'h00, "R8");
        run_op(1, 3'd3, 0, 2'd0, 8'hFF, 8'hFF, "R3");

        // Main sweep: ops x carry-in x accumulator x operand spread.
        for (int op = 0; op < 8; op++) begin
            for (int cy = 0; cy < 2; cy++) begin
                for (int a = 0; a < 256; a++) begin
                    for (int k = 0; k < 12; k++) begin
                        if (cy != 0) run_op(0, 3'd0, 1, 2'd1, 8'(a), 8'h00, "R8");
                        else         run_op(1, 3'd5, 0, 2'd0, 8'h01, 8'h00, "R4");
                        run_op(1, 3'(op), 0, 2'd0, 8'(a), opnd_pick(k),
                               req_of(1, 3'(op), 0, 2'd0));
                    end
                end
            end
        end

        // Single-operand sweep: each prep gives a distinct N/H pair.
        for (int a = 0; a < 256; a++) begin
            for (int m = 0; m < 4; m++) begin
                case (m)
                    0: run_op(1, 3'd5, 0, 2'd0, 8'h01, 8'h00, "R4");
                    1: run_op(1, 3'd4, 0, 2'd0, 8'h01, 8'h01, "R4");
                    2: run_op(1, 3'd2, 0, 2'd0, 8'h10, 8'h00, "R3");
                    default: run_op(0, 3'd0, 1, 2'd0, 8'h00, 8'h00, "R7");
                endcase
                run_op(0, 3'd0, 1, 2'd3, 8'(a), 8'h00, "R9");
            end
            run_op(0, 3'd0, 1, 2'd0, 8'(a), 8'h00, "R7");
            run_op(0, 3'd0, 1, 2'd2, 8'(a), 8'h00, "R8");
            run_op(0, 3'd0, 1, 2'd2, 8'(a), 8'h00, "R8");
        end

        run_op(1'b0, 3'd0, 1'b0, 2'd0, 8'h5A, 8'hA5, "R10");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule